// File: doc/BRIEF.md
# MMC host register file

This block is the software-visible register file of an MMC/SD host controller. A simple 16-bit read/write port reaches it with 7-bit byte offsets. The file holds the 32-bit command argument, the interface configuration, the interrupt status and enable words, the two timeout values, the block length and block count with a byte counter, the buffer threshold settings, and eight response words. A single level interrupt is high while any status bit is set and also enabled.

The command engine sits outside this block. A write to the command word, when the interface is enabled, raises `cmdStart` for that cycle. The engine then reports completion through `cmdDone`, with `cmdTimeout` qualifying it and the captured response on `rspWords`. The register file turns that report into status bits and response words.

Software clears status by writing ones. A write of bit 2 to the system-config word resets the whole file back to its power-up values.

Top module: `mmc_host_regs`

## Requirements
- R1: `irq` is high exactly when some bit of (status & interrupt-enable) is 1. It reflects each register change from the cycle after the change.
- R2: A write to offset 0x10 clears each status bit whose written bit is 1 and leaves the others unchanged. A completion set in the same cycle takes precedence over the clear.
- R3: Interrupt enable (offset 0x14) stores bits 14:0 of the written word; bit 15 reads back 0.
- R4: The argument is written as a low half at 0x04 and a high half at 0x08. Each write replaces only its own half, and each half reads back at its offset.
- R5: The configuration word at 0x0C holds data width in bit 15, mode in bits 13:12, enable in bit 11, byte-order in bit 10 and the clock divider in bits 9:0; bit 14 reads 0. A write to the command word at 0x00 is stored and pulses `cmdStart` in the same cycle only when enable is 1. Otherwise it changes nothing.
- R6: Block length (0x24) and block count (0x28) store written bits 10:0 plus one. A length write loads the byte counter with the new length, and a count write reloads it from the stored length. 0x24 reads the byte counter and 0x28 reads the count.
- R7: On `cmdDone`, a timeout sets status bit 7. Otherwise a command word whose bits 5:0 equal 12 sets bits 0 and 2, and any other sets bit 0. A completion without timeout captures `rspWords` (word i from bits 16i+15:16i).
- R8: Command timeout (0x18) keeps 8 bits; data timeout (0x1C) keeps 16 bits.
- R9: Offset 0x68 always reads 1. A write to 0x64 with bit 2 set returns every register to its reset value on the next edge, while other values there do nothing.
- R10: Response words 0 to 7 read at 0x40 to 0x5C. Writes there, and to the revision word at 0x3C (which reads the `REV_ID` parameter), are ignored.
- R11: A read of an unaligned offset or one above 0x68 returns 0 and raises `badAccess` for one cycle. Mapped reads never raise it.
- R12: While `rstN` is low, every register and output is 0.
- R13: The buffer word at 0x2C holds the receive DMA enable in bit 15, the almost-full level in bits 12:8, the transmit DMA enable in bit 7 and the almost-empty level in bits 4:0; other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | 7 | Byte offset of the access |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, registered |
| badAccess | output | 1 | One-cycle pulse after a read of an unmapped offset |
| irq | output | 1 | Level interrupt |
| cmdStart | output | 1 | Accepted command write, combinational |
| cmdDone | input | 1 | Command completion from the command engine |
| cmdTimeout | input | 1 | Qualifies `cmdDone` as a timeout |
| rspWords | input | 128 | Response words captured on completion |

## Verification
`rdData` and `badAccess` come from the clock edge that samples `rdEn`. `irq` follows the state written at an edge in that same cycle. `cmdStart` is valid during the write cycle itself. The bench applies inputs on the falling edge, advances its behavioural model on each rising edge, and compares all four outputs a quarter period after that edge. At that point every registered result of that edge has settled and the inputs have not yet moved.

// File: rtl/mmc_regs_pkg.sv
package mmc_regs_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int RSP_N  = 8;
  localparam int LEN_W  = 11;
  localparam int CNT_W  = LEN_W + 1;

  localparam logic [ADDR_W-1:0] OFF_CMD     = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_ARG_LO  = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_ARG_HI  = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_CON     = 7'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 7'h10;
  localparam logic [ADDR_W-1:0] OFF_IE      = 7'h14;
  localparam logic [ADDR_W-1:0] OFF_CTO     = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_DTO     = 7'h1C;
  localparam logic [ADDR_W-1:0] OFF_BLEN    = 7'h24;
  localparam logic [ADDR_W-1:0] OFF_NBLK    = 7'h28;
  localparam logic [ADDR_W-1:0] OFF_BUF     = 7'h2C;
  localparam logic [ADDR_W-1:0] OFF_REV     = 7'h3C;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG  = 7'h64;
  localparam logic [ADDR_W-1:0] OFF_SYSSTAT = 7'h68;

  localparam logic [DATA_W-1:0] STAT_END  = 16'h0001;
  localparam logic [DATA_W-1:0] STAT_STOP = 16'h0004;
  localparam logic [DATA_W-1:0] STAT_TMO  = 16'h0080;
  localparam logic [5:0]        CMD_STOP  = 6'd12;

  typedef struct packed {
    logic cmd;
    logic argLo;
    logic argHi;
    logic con;
    logic stat;
    logic ie;
    logic cto;
    logic dto;
    logic blen;
    logic nblk;
    logic bufCfg;
    logic softRst;
  } regStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] cmd;
    logic [31:0]       arg;
    logic              dw;
    logic [1:0]        mode;
    logic              en;
    logic              be;
    logic [9:0]        clkDiv;
    logic [DATA_W-1:0] stat;
    logic [14:0]       ie;
    logic [7:0]        cto;
    logic [15:0]       dto;
    logic [CNT_W-1:0]  blen;
    logic [CNT_W-1:0]  nblk;
    logic [CNT_W-1:0]  byteCnt;
    logic              rxDma;
    logic [4:0]        afLvl;
    logic              txDma;
    logic [4:0]        aeLvl;
  } cfgRegs_t;

endpackage

// File: rtl/mmc_regs_ctrl.sv
module mmc_regs_ctrl
  import mmc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              softBit,
  input  logic              conEn,
  output regStrobes_t       stb,
  output logic              rdBad
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (addr)
        OFF_CMD:    stb.cmd     = conEn;
        OFF_ARG_LO: stb.argLo   = 1'b1;
        OFF_ARG_HI: stb.argHi   = 1'b1;
        OFF_CON:    stb.con     = 1'b1;
        OFF_STAT:   stb.stat    = 1'b1;
        OFF_IE:     stb.ie      = 1'b1;
        OFF_CTO:    stb.cto     = 1'b1;
        OFF_DTO:    stb.dto     = 1'b1;
        OFF_BLEN:   stb.blen    = 1'b1;
        OFF_NBLK:   stb.nblk    = 1'b1;
        OFF_BUF:    stb.bufCfg  = 1'b1;
        OFF_SYSCFG: stb.softRst = softBit;
        default:    stb = '0;
      endcase
    end
  end

  assign rdBad = rdEn && ((addr[1:0] != 2'b00) || (addr > OFF_SYSSTAT));

  // R5: one register is touched per write
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R5: no command accepted while the interface is disabled
  a_r5_cmd_gated: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_CMD && !conEn) |-> !stb.cmd);

endmodule

// File: rtl/mmc_regs_dp.sv
module mmc_regs_dp
  import mmc_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID = 16'h0001
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobes_t             stb,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    rdEn,
  input  logic                    rdBad,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cmdDone,
  input  logic                    cmdTimeout,
  input  logic [RSP_N*DATA_W-1:0] rspWords,
  output logic [DATA_W-1:0]       rdData,
  output logic                    badAccess,
  output logic                    irq,
  output logic                    conEn
);

  cfgRegs_t cfgQ, cfgD;
  logic [RSP_N-1:0][DATA_W-1:0] rspQ;
  logic [DATA_W-1:0] setBits, clrBits, rdNext;

  always_comb begin
    setBits = '0;
    if (cmdDone) begin
      if (cmdTimeout)                     setBits = STAT_TMO;
      else if (cfgQ.cmd[5:0] == CMD_STOP) setBits = STAT_END | STAT_STOP;
      else                                setBits = STAT_END;
    end
    clrBits = stb.stat ? wrData : '0;

    cfgD = cfgQ;
    cfgD.stat = (cfgQ.stat & ~clrBits) | setBits;
    if (stb.cmd)   cfgD.cmd = wrData;
    if (stb.argLo) cfgD.arg[15:0] = wrData;
    if (stb.argHi) cfgD.arg[31:16] = wrData;
    if (stb.con) begin
      cfgD.dw     = wrData[15];
      cfgD.mode   = wrData[13:12];
      cfgD.en     = wrData[11];
      cfgD.be     = wrData[10];
      cfgD.clkDiv = wrData[9:0];
    end
    if (stb.ie)  cfgD.ie  = wrData[14:0];
    if (stb.cto) cfgD.cto = wrData[7:0];
    if (stb.dto) cfgD.dto = wrData;
    if (stb.blen) begin
      cfgD.blen    = {1'b0, wrData[LEN_W-1:0]} + CNT_W'(1);
      cfgD.byteCnt = {1'b0, wrData[LEN_W-1:0]} + CNT_W'(1);
    end
    if (stb.nblk) begin
      cfgD.nblk    = {1'b0, wrData[LEN_W-1:0]} + CNT_W'(1);
      cfgD.byteCnt = cfgQ.blen;
    end
    if (stb.bufCfg) begin
      cfgD.rxDma = wrData[15];
      cfgD.afLvl = wrData[12:8];
      cfgD.txDma = wrData[7];
      cfgD.aeLvl = wrData[4:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (stb.softRst) cfgQ <= '0;
    else                  cfgQ <= cfgD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rspQ <= '0;
    else if (stb.softRst)             rspQ <= '0;
    else if (cmdDone && !cmdTimeout)  rspQ <= rspWords;
  end

  always_comb begin
    rdNext = '0;
    if (addr[6:5] == 2'b10 && addr[1:0] == 2'b00) begin
      rdNext = rspQ[addr[4:2]];
    end else begin
      case (addr)
        OFF_CMD:     rdNext = cfgQ.cmd;
        OFF_ARG_LO:  rdNext = cfgQ.arg[15:0];
        OFF_ARG_HI:  rdNext = cfgQ.arg[31:16];
        OFF_CON:     rdNext = {cfgQ.dw, 1'b0, cfgQ.mode, cfgQ.en, cfgQ.be, cfgQ.clkDiv};
        OFF_STAT:    rdNext = cfgQ.stat;
        OFF_IE:      rdNext = {1'b0, cfgQ.ie};
        OFF_CTO:     rdNext = {8'h00, cfgQ.cto};
        OFF_DTO:     rdNext = cfgQ.dto;
        OFF_BLEN:    rdNext = {{(DATA_W-CNT_W){1'b0}}, cfgQ.byteCnt};
        OFF_NBLK:    rdNext = {{(DATA_W-CNT_W){1'b0}}, cfgQ.nblk};
        OFF_BUF:     rdNext = {cfgQ.rxDma, 2'b00, cfgQ.afLvl, cfgQ.txDma, 2'b00, cfgQ.aeLvl};
        OFF_REV:     rdNext = REV_ID;
        OFF_SYSSTAT: rdNext = 16'h0001;
        default:     rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      badAccess <= 1'b0;
    end else begin
      badAccess <= rdBad;
      if (rdEn) rdData <= rdBad ? '0 : rdNext;
    end
  end

  assign irq   = |(cfgQ.stat & {1'b0, cfgQ.ie});
  assign conEn = cfgQ.en;

  // R2: clearing every bit with no completion pending silences the interrupt
  a_r2_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stat && wrData == 16'hFFFF && !cmdDone) |=> !irq);

  // R7: a timeout completion always leaves the timeout flag set
  a_r7_timeout_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && cmdTimeout && !stb.softRst) |=> cfgQ.stat[7]);

  // R9: soft reset empties the enable and argument registers
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (cfgQ.ie == '0 && cfgQ.arg == '0 && !irq));

  // R10: response words change only on a completion or soft reset
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdDone && !stb.softRst) |=> $stable(rspQ));

  // R11: the error pulse only follows a read
  a_r11_bad_after_read: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> $past(rdEn));

endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_regs_pkg::*;
#(
  parameter logic [15:0] REV_ID = 16'h0001
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [6:0]   addr,
  input  logic [15:0]  wrData,
  output logic [15:0]  rdData,
  output logic         badAccess,
  output logic         irq,
  output logic         cmdStart,
  input  logic         cmdDone,
  input  logic         cmdTimeout,
  input  logic [127:0] rspWords
);

  regStrobes_t stb;
  logic rdBad;
  logic conEn;

  mmc_regs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .softBit (wrData[2]),
    .conEn   (conEn),
    .stb     (stb),
    .rdBad   (rdBad)
  );

  mmc_regs_dp #(.REV_ID(REV_ID)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .rdBad      (rdBad),
    .addr       (addr),
    .cmdDone    (cmdDone),
    .cmdTimeout (cmdTimeout),
    .rspWords   (rspWords),
    .rdData     (rdData),
    .badAccess  (badAccess),
    .irq        (irq),
    .conEn      (conEn)
  );

  assign cmdStart = stb.cmd;

endmodule

// File: tb/mmc_host_regs_bench.sv
module mmc_host_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] REV = 16'h0031;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [6:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic badAccess, irq, cmdStart;
  logic cmdDone = 1'b0, cmdTimeout = 1'b0;
  logic [127:0] rspWords = '0;

  mmc_host_regs #(.REV_ID(REV)) u_mmc_host_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .badAccess(badAccess), .irq(irq),
    .cmdStart(cmdStart), .cmdDone(cmdDone), .cmdTimeout(cmdTimeout),
    .rspWords(rspWords)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string curTag = "R12";

  // behavioural model state
  logic [15:0] mCmd, mCon, mStat, mIe, mCto, mDto, mBuf;
  logic [31:0] mArg;
  logic [11:0] mBlen, mNblk, mByte;
  logic [15:0] mRsp [8];
  logic [15:0] expRd;
  logic expBad;
  bit rdPend;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mReset();
    mCmd = 0; mCon = 0; mStat = 0; mIe = 0; mCto = 0; mDto = 0; mBuf = 0;
    mArg = 0; mBlen = 0; mNblk = 0; mByte = 0;
    for (int i = 0; i < 8; i++) mRsp[i] = 0;
  endtask

  function automatic bit mMapped(input logic [6:0] a);
    return (a[1:0] == 2'b00) && (a <= 7'h68);
  endfunction

  function automatic logic [15:0] mRead(input logic [6:0] a);
    if (!mMapped(a)) return 16'h0;
    if (a >= 7'h40 && a <= 7'h5C) return mRsp[(a - 7'h40) >> 2];
    case (a)
      7'h00: return mCmd;
      7'h04: return mArg[15:0];
      7'h08: return mArg[31:16];
      7'h0C: return mCon;
      7'h10: return mStat;
      7'h14: return mIe;
      7'h18: return mCto;
      7'h1C: return mDto;
      7'h24: return {4'h0, mByte};
      7'h28: return {4'h0, mNblk};
      7'h2C: return mBuf;
      7'h3C: return REV;
      7'h68: return 16'h0001;
      default: return 16'h0;
    endcase
  endfunction

  task automatic step();
    logic [15:0] setB, clrB;
    rdPend = rdEn;
    expBad = rdEn && !mMapped(addr);
    if (rdEn) expRd = mRead(addr);
    setB = 0;
    if (cmdDone) setB = cmdTimeout ? 16'h0080 : ((mCmd[5:0] == 6'd12) ? 16'h0005 : 16'h0001);
    clrB = (wrEn && addr == 7'h10) ? wrData : 16'h0;
    if (wrEn && addr == 7'h64 && wrData[2]) begin
      mReset();
    end else begin
      if (cmdDone && !cmdTimeout)
        for (int i = 0; i < 8; i++) mRsp[i] = rspWords[16*i +: 16];
      if (wrEn) begin
        case (addr)
          7'h00: if (mCon[11]) mCmd = wrData;
          7'h04: mArg[15:0] = wrData;
          7'h08: mArg[31:16] = wrData;
          7'h0C: mCon = wrData & 16'hBFFF;
          7'h14: mIe = wrData & 16'h7FFF;
          7'h18: mCto = wrData & 16'h00FF;
          7'h1C: mDto = wrData;
          7'h24: begin mBlen = 12'(wrData[10:0]) + 12'd1; mByte = mBlen; end
          7'h28: begin mNblk = 12'(wrData[10:0]) + 12'd1; mByte = mBlen; end
          7'h2C: mBuf = wrData & 16'h9F9F;
          default: ;
        endcase
      end
      mStat = (mStat & ~clrB) | setB;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReset();
      expRd = 0; expBad = 0; rdPend = 0;
    end else begin
      step();
      #2;
      chk("R1 irq", irq, |(mStat & mIe));
      chk("R11 badAccess", badAccess, expBad);
      chk("R5 cmdStart", cmdStart, wrEn && addr == 7'h00 && mCon[11]);
      if (rdPend) chk(curTag, rdData, expRd);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    @(negedge clk); rdEn = 1; addr = a; curTag = tag;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic done(input logic to);
    @(negedge clk); cmdDone = 1; cmdTimeout = to;
    @(negedge clk); cmdDone = 0; cmdTimeout = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R12: values held during reset
    chk("R12 rdData in reset", rdData, 16'h0);
    chk("R12 irq in reset", irq, 1'b0);
    chk("R12 badAccess in reset", badAccess, 1'b0);
    @(negedge clk); rstN = 1;
    for (int a = 0; a <= 'h68; a += 4) rd(7'(a), "R12 reset value");
    rd(7'h68, "R9 system status");
    // R3
    wr(7'h14, 16'hFFFF); rd(7'h14, "R3 enable mask");
    wr(7'h14, 16'h0000);
    // R4
    wr(7'h04, 16'h1234); wr(7'h08, 16'hABCD);
    rd(7'h04, "R4 arg low"); rd(7'h08, "R4 arg high");
    wr(7'h04, 16'h5A5A); rd(7'h08, "R4 high kept"); rd(7'h04, "R4 low replaced");
    // R5
    wr(7'h0C, 16'hFFFF); rd(7'h0C, "R5 config layout");
    wr(7'h0C, 16'h0000); wr(7'h00, 16'h0011); rd(7'h00, "R5 command ignored");
    wr(7'h0C, 16'h0800); wr(7'h00, 16'h000C); rd(7'h00, "R5 command stored");
    // R7 stop command, R1 interrupt
    rspWords = 128'h7777_6666_5555_4444_3333_2222_1111_0F0F;
    done(1'b0); rd(7'h10, "R7 stop completion");
    wr(7'h14, 16'h0001);
    wr(7'h10, 16'h0004); rd(7'h10, "R2 partial clear");
    wr(7'h10, 16'h0000); rd(7'h10, "R2 zero write");
    wr(7'h10, 16'h0001); rd(7'h10, "R2 full clear");
    wr(7'h00, 16'h0011);
    rspWords = 128'hDEAD_BEEF_0000_FFFF_1357_2468_ACE0_BDF1;
    done(1'b1); rd(7'h10, "R7 timeout flag"); rd(7'h40, "R7 rsp kept on timeout");
    wr(7'h14, 16'h0080);
    done(1'b0); rd(7'h10, "R7 normal completion");
    for (int i = 0; i < 8; i++) rd(7'(7'h40 + 4*i), "R10 response word");
    wr(7'h44, 16'h9999); wr(7'h3C, 16'h9999);
    rd(7'h44, "R10 response read-only"); rd(7'h3C, "R10 revision");
    // R2 same-cycle set and clear
    wr(7'h10, 16'hFFFF);
    @(negedge clk); wrEn = 1; addr = 7'h10; wrData = 16'hFFFF; cmdDone = 1;
    @(negedge clk); wrEn = 0; cmdDone = 0;
    rd(7'h10, "R2 set wins over clear");
    // R6
    wr(7'h24, 16'hFFFF); rd(7'h24, "R6 length max");
    wr(7'h24, 16'h0010); wr(7'h28, 16'h0003);
    rd(7'h28, "R6 count"); rd(7'h24, "R6 byte counter reload");
    // R8
    wr(7'h18, 16'h01FF); rd(7'h18, "R8 command timeout");
    wr(7'h1C, 16'hFFFF); rd(7'h1C, "R8 data timeout");
    // R13
    wr(7'h2C, 16'hFFFF); rd(7'h2C, "R13 buffer layout");
    wr(7'h2C, 16'h8A85); rd(7'h2C, "R13 buffer pattern");
    // R11
    rd(7'h6C, "R11 above map"); rd(7'h7C, "R11 top offset"); rd(7'h02, "R11 unaligned");
    // R9
    wr(7'h64, 16'h0003); rd(7'h14, "R9 no reset without bit 2");
    wr(7'h64, 16'h0004);
    rd(7'h14, "R9 soft reset enable"); rd(7'h04, "R9 soft reset arg");
    rd(7'h2C, "R9 soft reset buffer"); rd(7'h40, "R9 soft reset response");
    rd(7'h68, "R9 system status after reset");
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule